// File: doc/BRIEF.md
# DRAM Geometry Aliasing Probe

This block runs once the memory controller and its physical layer are up and answering reads. It discovers how many column bits, row bits and banks the attached DRAM has. Above its real size, a part repeats its contents, so the block looks for that repetition. For each candidate power-of-two offset it reads a window of consecutive 32-bit words at the base address and at the base plus the offset, one word of each per step. If every pair matches, the offset is counted as aliased.

Three sweeps run in a fixed order. The column sweep finds the first aliasing column exponent. The row sweep builds its offsets from the column result. A single bank probe then builds its offset from both. At the end the block reports the column bits, page size, row bits, bank code and total capacity. Capacity also depends on the rank and channel terms that the caller supplies. The memory port is a single-outstanding word-read port: the block sends a one-cycle request and waits for a response strobe.

Top module: `geo_probe`

## Requirements
- R1: A candidate offset counts as aliased only if all 64 word pairs compare equal. A difference in any single word rejects the candidate, including a difference in the last word (index 63). Reading for that candidate stops at the first differing pair.
- R2: The column sweep tries exponents c = 7, 8, ... 19 in ascending order, using offset 1<<c, and stops at the first aliased one. If none aliases, the found value is 20. `col_bits_o` equals the found value minus the bus factor. The bus factor is 2 when `bus32_i` = 1 (32-bit bus) and 1 when `bus32_i` = 0 (16-bit bus).
- R3: `page_bytes_o` equals (1 << col_bits) × (bus factor × 2).
- R4: The row sweep tries r = 11 ... 15 in ascending order, using offset 1 << (r + col_bits + bus factor), and stops at the first aliased one. If none aliases, `row_bits_o` is 16.
- R5: The bank probe uses the single offset 1 << (row_bits + col_bits + bus factor + 2). If it aliases, `bank_code_o` = 0 (four banks); otherwise `bank_code_o` = 1 (eight banks).
- R6: `size_bytes_o` = 1 << (rank + row_bits + bank_code + col_bits + chan + bus factor). Here rank and chan are the unsigned values of `rank_i` and `chan_i`. These values and `bus32_i` are captured in the cycle that a start is accepted.
- R7: For word index i, running 0 to 63, the block first reads byte address BASE + 4·i and then BASE + offset + 4·i. Each request is a one-cycle `mem_req_o` pulse. No new request is issued until `mem_rvalid_i` has answered the previous one.
- R8: `done_o` rises only after the last read of the bank probe has been answered. It stays high until a start is accepted and is low in the cycle after that start. A start pulse while a sweep is running has no effect on the read sequence or on the results.
- R9: After reset, `done_o` and `mem_req_o` are low and all result fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; accepted only when idle or done |
| bus32_i | input | 1 | 1 = 32-bit data bus, 0 = 16-bit |
| rank_i | input | 2 | Rank term of the capacity exponent |
| chan_i | input | 2 | Channel term of the capacity exponent |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | ADDR_W | Byte address of the request |
| mem_rvalid_i | input | 1 | Read response strobe |
| mem_rdata_i | input | 32 | Read response data |
| done_o | output | 1 | Results valid |
| col_bits_o | output | 5 | Column bit count |
| row_bits_o | output | 5 | Row bit count |
| bank_code_o | output | 1 | 0 = four banks, 1 = eight banks |
| page_bytes_o | output | 32 | Page size in bytes |
| size_bytes_o | output | 64 | Total capacity in bytes |

## Verification
The assertions check, on every cycle, the protocol side of the block: requests are single-cycle pulses and never overlap an unanswered one; a candidate verdict never coincides with a request; `done_o` holds until a start and drops after one; and while `done_o` is high the row count is in range and the page size is a power of two. Whether the sweeps visit the right offsets in the right order, stop at the right candidate, reject a window that differs only in its final word, and compute the right capacity can only be shown by the bench. It runs scenarios whose memory model aliases on chosen address bits, and its reference model predicts every read address and the final fields.

// File: rtl/geo_pkg.sv
package geo_pkg;

  localparam int unsigned COL_FIRST = 7;
  localparam int unsigned COL_LAST  = 19;
  localparam int unsigned ROW_FIRST = 11;
  localparam int unsigned ROW_LAST  = 15;
  localparam int unsigned BANK_STEP = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_COL, PH_ROW, PH_BANK, PH_DONE
  } phase_e;

  typedef enum logic [2:0] {
    WS_IDLE, WS_REQ_BASE, WS_WAIT_BASE, WS_REQ_OFF, WS_WAIT_OFF
  } wstate_e;

  // bytes-per-beat exponent: 2 for a 32-bit bus, 1 for a 16-bit bus
  function automatic logic [4:0] bus_factor(input logic wide);
    return wide ? 5'd2 : 5'd1;
  endfunction

  function automatic logic [31:0] page_bytes(input logic [4:0] cols, input logic wide);
    return (32'd1 << cols) * ({27'd0, bus_factor(wide)} * 32'd2);
  endfunction

  function automatic logic [6:0] size_log(input logic [1:0] rank, input logic [4:0] rows,
                                          input logic bank, input logic [4:0] cols,
                                          input logic [1:0] chan, input logic wide);
    return 7'(rank) + 7'(rows) + 7'(bank) + 7'(cols) + 7'(chan) + 7'(bus_factor(wide));
  endfunction

endpackage

// File: rtl/geo_addr_gen.sv
module geo_addr_gen #(
  parameter int ADDR_W = 40,
  parameter int IDX_W  = 6,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              sel_off_i,
  input  logic [5:0]        exp_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] word_off;

  always_comb begin
    offset   = sel_off_i ? (ADDR_W'(1) << exp_i) : '0;
    word_off = ADDR_W'({idx_i, 2'b00});
    addr_o   = BASE + offset + word_off;
  end
endmodule

// File: rtl/geo_window_cmp.sv
module geo_window_cmp
  import geo_pkg::*;
#(
  parameter int WORDS  = 64,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic              rvalid_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              sel_off_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              cand_done_o,
  output logic              cand_alias_o
);
  wstate_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] hold_q;
  logic              same;
  logic              last;

  assign same = (rdata_i == hold_q);
  assign last = (idx_q == IDX_W'(WORDS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WS_IDLE;
      idx_q  <= '0;
      hold_q <= '0;
    end else begin
      case (st_q)
        WS_IDLE: if (kick_i) begin
          st_q  <= WS_REQ_BASE;
          idx_q <= '0;
        end
        WS_REQ_BASE: st_q <= WS_WAIT_BASE;
        WS_WAIT_BASE: if (rvalid_i) begin
          hold_q <= rdata_i;
          st_q   <= WS_REQ_OFF;
        end
        WS_REQ_OFF: st_q <= WS_WAIT_OFF;
        WS_WAIT_OFF: if (rvalid_i) begin
          if (!same || last) begin
            st_q <= WS_IDLE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= WS_REQ_BASE;
          end
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  assign req_o        = (st_q == WS_REQ_BASE) || (st_q == WS_REQ_OFF);
  assign sel_off_o    = (st_q == WS_REQ_OFF) || (st_q == WS_WAIT_OFF);
  assign idx_o        = idx_q;
  assign cand_done_o  = (st_q == WS_WAIT_OFF) && rvalid_i && (!same || last);
  assign cand_alias_o = same;
endmodule

// File: rtl/geo_sweep_ctrl.sv
module geo_sweep_ctrl
  import geo_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        bus32_i,
  input  logic [1:0]  rank_i,
  input  logic [1:0]  chan_i,
  input  logic        cand_done_i,
  input  logic        cand_alias_i,
  output logic        kick_o,
  output logic [5:0]  exp_o,
  output logic        done_o,
  output logic [4:0]  col_bits_o,
  output logic [4:0]  row_bits_o,
  output logic        bank_code_o,
  output logic [31:0] page_bytes_o,
  output logic [63:0] size_bytes_o
);
  phase_e      phase_q;
  logic [4:0]  trial_q, cols_q, rows_q;
  logic        wide_q, bank_q, kick_q;
  logic [1:0]  rank_q, chan_q;
  logic [31:0] page_q;
  logic [63:0] size_q;
  logic [4:0]  busf;
  logic        accept, col_stop, row_stop;
  logic [4:0]  col_found, row_found;

  assign busf      = bus_factor(wide_q);
  assign accept    = start_i && (phase_q == PH_IDLE || phase_q == PH_DONE);
  assign col_stop  = cand_alias_i || (trial_q == 5'(COL_LAST));
  assign row_stop  = cand_alias_i || (trial_q == 5'(ROW_LAST));
  assign col_found = cand_alias_i ? trial_q : 5'(COL_LAST + 1);
  assign row_found = cand_alias_i ? trial_q : 5'(ROW_LAST + 1);

  always_comb begin
    case (phase_q)
      PH_COL:  exp_o = 6'(trial_q);
      PH_ROW:  exp_o = 6'(trial_q) + 6'(cols_q) + 6'(busf);
      PH_BANK: exp_o = 6'(rows_q) + 6'(cols_q) + 6'(busf) + 6'(BANK_STEP);
      default: exp_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      trial_q <= '0;
      cols_q  <= '0;
      rows_q  <= '0;
      wide_q  <= 1'b0;
      bank_q  <= 1'b0;
      kick_q  <= 1'b0;
      rank_q  <= '0;
      chan_q  <= '0;
      page_q  <= '0;
      size_q  <= '0;
    end else begin
      kick_q <= 1'b0;
      if (accept) begin
        phase_q <= PH_COL;
        trial_q <= 5'(COL_FIRST);
        wide_q  <= bus32_i;
        rank_q  <= rank_i;
        chan_q  <= chan_i;
        kick_q  <= 1'b1;
      end else if (cand_done_i) begin
        case (phase_q)
          PH_COL: begin
            kick_q <= 1'b1;
            if (col_stop) begin
              cols_q  <= col_found - busf;
              phase_q <= PH_ROW;
              trial_q <= 5'(ROW_FIRST);
            end else begin
              trial_q <= trial_q + 5'd1;
            end
          end
          PH_ROW: begin
            kick_q <= 1'b1;
            if (row_stop) begin
              rows_q  <= row_found;
              phase_q <= PH_BANK;
            end else begin
              trial_q <= trial_q + 5'd1;
            end
          end
          PH_BANK: begin
            bank_q  <= !cand_alias_i;
            page_q  <= page_bytes(cols_q, wide_q);
            size_q  <= 64'd1 << size_log(rank_q, rows_q, !cand_alias_i, cols_q, chan_q, wide_q);
            phase_q <= PH_DONE;
          end
          default: phase_q <= phase_q;
        endcase
      end
    end
  end

  assign kick_o       = kick_q;
  assign done_o       = (phase_q == PH_DONE);
  assign col_bits_o   = cols_q;
  assign row_bits_o   = rows_q;
  assign bank_code_o  = bank_q;
  assign page_bytes_o = page_q;
  assign size_bytes_o = size_q;
endmodule

// File: rtl/geo_probe.sv
module geo_probe #(
  parameter int ADDR_W = 40,
  parameter int WORDS  = 64,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              bus32_i,
  input  logic [1:0]        rank_i,
  input  logic [1:0]        chan_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic [4:0]        col_bits_o,
  output logic [4:0]        row_bits_o,
  output logic              bank_code_o,
  output logic [31:0]       page_bytes_o,
  output logic [63:0]       size_bytes_o
);
  localparam int IDX_W  = $clog2(WORDS);
  localparam int DATA_W = 32;

  // internal events, named for the bound checker
  logic             kick;
  logic [5:0]       cand_exp;
  logic             cand_done;
  logic             cand_alias;
  logic             sel_off;
  logic [IDX_W-1:0] word_idx;

  geo_sweep_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .bus32_i      (bus32_i),
    .rank_i       (rank_i),
    .chan_i       (chan_i),
    .cand_done_i  (cand_done),
    .cand_alias_i (cand_alias),
    .kick_o       (kick),
    .exp_o        (cand_exp),
    .done_o       (done_o),
    .col_bits_o   (col_bits_o),
    .row_bits_o   (row_bits_o),
    .bank_code_o  (bank_code_o),
    .page_bytes_o (page_bytes_o),
    .size_bytes_o (size_bytes_o)
  );

  geo_window_cmp #(.WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .kick_i       (kick),
    .rvalid_i     (mem_rvalid_i),
    .rdata_i      (mem_rdata_i),
    .req_o        (mem_req_o),
    .sel_off_o    (sel_off),
    .idx_o        (word_idx),
    .cand_done_o  (cand_done),
    .cand_alias_o (cand_alias)
  );

  geo_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .BASE(BASE)) u_addr (
    .sel_off_i (sel_off),
    .exp_i     (cand_exp),
    .idx_i     (word_idx),
    .addr_o    (mem_addr_o)
  );
endmodule

// File: rtl/geo_probe_chk.sv
module geo_probe_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        mem_req_o,
  input logic        mem_rvalid_i,
  input logic        done_o,
  input logic [4:0]  row_bits_o,
  input logic [31:0] page_bytes_o,
  input logic        cand_done
);
  logic outstanding;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           outstanding <= 1'b0;
    else if (mem_req_o)    outstanding <= 1'b1;
    else if (mem_rvalid_i) outstanding <= 1'b0;
  end

  p_single_outstanding_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !outstanding);

  p_req_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_verdict_apart_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cand_done, mem_req_o}));

  p_done_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);

  p_start_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && start_i) |=> !done_o);

  p_quiet_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_req_o && !cand_done));

  p_row_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (row_bits_o >= 5'd11 && row_bits_o <= 5'd16));

  p_page_pow2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(page_bytes_o) == 1));
endmodule

bind geo_probe geo_probe_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .mem_req_o    (mem_req_o),
  .mem_rvalid_i (mem_rvalid_i),
  .done_o       (done_o),
  .row_bits_o   (row_bits_o),
  .page_bytes_o (page_bytes_o),
  .cand_done    (cand_done)
);

// File: tb/geo_probe_tb.sv
`timescale 1ns/1ps
module geo_probe_tb;
  localparam int ADDR_W = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic bus32 = 1'b0;
  logic [1:0] rank = '0;
  logic [1:0] chan = '0;
  logic rvalid = 1'b0;
  logic [31:0] rdata = '0;
  wire mem_req;
  wire [ADDR_W-1:0] mem_addr;
  wire done;
  wire [4:0] colb;
  wire [4:0] rowb;
  wire bank;
  wire [31:0] page;
  wire [63:0] size;

  always #2.5 clk = ~clk;

  geo_probe #(.ADDR_W(ADDR_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bus32_i(bus32),
    .rank_i(rank), .chan_i(chan), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(rvalid), .mem_rdata_i(rdata), .done_o(done),
    .col_bits_o(colb), .row_bits_o(rowb), .bank_code_o(bank),
    .page_bytes_o(page), .size_bytes_o(size)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  longint unsigned ign_mask = 0;
  longint unsigned poison_addr = 0;
  bit poison_en = 0;
  int lat = 1;
  int rsp_cnt = 0;
  longint unsigned rsp_addr = 0;
  longint unsigned exp_q[$];
  bit mon_on = 0;

  // memory that ignores the address bits in ign_mask; one optional corrupted word
  function automatic logic [31:0] mem_word(input longint unsigned a);
    logic [39:0] x;
    logic [31:0] v;
    x = 40'(a & ~ign_mask);
    v = (x[31:0] ^ {x[39:32], 24'h0}) * 32'h9E3779B1 + 32'h01375A5A;
    if (poison_en && a == poison_addr) v = v ^ 32'h1;
    return v;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  // reference model: expected read stream of one candidate window
  function automatic bit walk(input longint unsigned off);
    for (int i = 0; i < 64; i++) begin
      longint unsigned a;
      longint unsigned b;
      a = longint'(i) * 4;
      b = off + a;
      exp_q.push_back(a);
      exp_q.push_back(b);
      if (mem_word(a) != mem_word(b)) return 1'b0;
    end
    return 1'b1;
  endfunction

  // per-clock memory responder and comparison against the model
  always @(negedge clk) begin
    if (mon_on && done && (exp_q.size() != 0 || rsp_cnt != 0))
      chk(1'b0, "R8", "done before last read answered", 1, 0);
    rvalid = 1'b0;
    if (rsp_cnt > 0) begin
      rsp_cnt--;
      if (rsp_cnt == 0) begin
        rvalid = 1'b1;
        rdata  = mem_word(rsp_addr);
      end
    end
    if (mon_on && mem_req) begin
      if (rsp_cnt != 0 || rvalid) chk(1'b0, "R7", "request while one outstanding", 1, 0);
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected read address", longint'(mem_addr), -1);
      end else begin
        chk(longint'(mem_addr) == longint'(exp_q[0]), "R7", "read address",
            longint'(mem_addr), longint'(exp_q[0]));
        void'(exp_q.pop_front());
      end
    end
    if (mem_req) begin
      rsp_cnt  = lat;
      rsp_addr = longint'(mem_addr);
    end
  end

  task automatic run_case(input bit w, input int cf, input int rf, input bit balias,
                          input int rk, input int ch, input int lt,
                          input int poison_exp, input bit poke);
    int busf, cols, cols_m, c_got, r_got, bnk, cyc;
    bit al;
    longint unsigned pg, sz;
    busf = w ? 2 : 1;
    cols = cf - busf;
    ign_mask = 0;
    poison_en = 0;
    if (cf < 20) ign_mask |= 64'd1 << cf;
    if (rf < 16) ign_mask |= 64'd1 << (rf + cols + busf);
    if (balias)  ign_mask |= 64'd1 << (rf + cols + busf + 2);
    if (poison_exp > 0) begin
      ign_mask |= 64'd1 << poison_exp;
      poison_en = 1;
      poison_addr = (64'd1 << poison_exp) + 252;
    end
    lat = lt;
    exp_q.delete();
    c_got = 20;
    for (int c = 7; c <= 19; c++) if (walk(64'd1 << c)) begin c_got = c; break; end
    cols_m = c_got - busf;
    r_got = 16;
    for (int r = 11; r <= 15; r++)
      if (walk(64'd1 << (r + cols_m + busf))) begin r_got = r; break; end
    al = walk(64'd1 << (r_got + cols_m + busf + 2));
    pg  = (64'd1 << cols) * longint'(busf * 2);
    bnk = balias ? 0 : 1;
    sz  = 64'd1 << (rk + rf + bnk + cols + ch + busf);

    @(negedge clk);
    bus32 = w; rank = 2'(rk); chan = 2'(ch); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R8", "done low after start", longint'(done), 0);
    mon_on = 1;
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke && cyc == 40) begin start = 1'b1; bus32 = ~w; rank = ~rank; chan = ~chan; end
      if (poke && cyc == 41) begin start = 1'b0; bus32 = w; rank = 2'(rk); chan = 2'(ch); end
    end
    chk(cyc < 20000, "R8", "probe finished", cyc, 20000);
    chk(exp_q.size() == 0, "R7", "expected reads left unissued", exp_q.size(), 0);
    chk(c_got == cf && r_got == rf && al == balias, "R2", "model scenario consistent", c_got, cf);
    chk(colb == 5'(cols), "R2", "column bits", colb, cols);
    if (poison_exp > 0)
      chk(colb != 5'(poison_exp - busf), "R1", "last-word mismatch rejected", colb, cols);
    chk(page == 32'(pg), "R3", "page bytes", page, longint'(pg));
    chk(rowb == 5'(rf), "R4", "row bits", rowb, rf);
    chk(bank == 1'(bnk), "R5", "bank code", bank, bnk);
    chk(size == sz, "R6", "total size", longint'(size), longint'(sz));
    repeat (3) @(negedge clk);
    chk(done == 1'b1, "R8", "done held until next start", done, 1);
    mon_on = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 1'b0, "R9", "done after reset", done, 0);
    chk(mem_req == 1'b0, "R9", "no request after reset", mem_req, 0);
    chk(colb == 0 && rowb == 0 && bank == 0, "R9", "fields after reset", colb, 0);
    chk(page == 0 && size == 0, "R9", "page and size after reset", page, 0);
    // 32-bit bus, mid-range geometry, bank alias
    run_case(1'b1, 10, 13, 1'b1, 1, 1, 1, 0, 1'b0);
    // 16-bit bus, slow memory, start poked while busy
    run_case(1'b0, 9, 11, 1'b0, 2, 2, 3, 0, 1'b1);
    // nothing aliases anywhere
    run_case(1'b1, 20, 16, 1'b0, 1, 2, 1, 0, 1'b0);
    // near-miss candidate differing only in word 63
    run_case(1'b0, 12, 14, 1'b1, 2, 1, 2, 9, 1'b0);
    // aliasing found at the last candidate of each sweep
    run_case(1'b1, 19, 15, 1'b1, 2, 2, 2, 0, 1'b0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    finished = 1;
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired: actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule